// File: doc/BRIEF.md
# Serial Receive Queue with Per-Frame Status

This block sits behind the bit sampler of a serial receiver and holds completed frames until software collects them. Two storage slots form a circular queue. Each slot keeps the received byte together with its ninth data bit, a frame-error flag and a data-overrun flag, so the status a reader sees always belongs to the byte at the head of the queue.

The receive shifter acts as a third storage level. When both slots are occupied, a newly completed frame stays parked in the shifter. It moves into the queue at the clock edge where a slot is freed by a pop. It is discarded only if a new start bit arrives while it is still parked and both slots are still full. That loss is reported on the next frame that enters the queue.

A reader first looks at the status outputs, then pops. The status of an entry disappears together with it. Deasserting the enable flushes everything.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset `data_avail` is 0 and the data, ninth-bit, frame-error and overrun outputs read 0.
- R2: Frames leave in the order they were completed. Each pop of a non-empty queue removes exactly one entry, and at most two entries are stored.
- R3: The ninth bit and frame-error flag of a frame are stored with its byte. The status outputs always show the flags of the entry whose byte is on `rd_data`.
- R4: A frame completed while both slots are full and no pop is in progress is held in the shifter. It is not visible on the outputs and is not lost.
- R5: A held frame enters the queue at the same clock edge as the pop that frees a slot, behind the entries already queued.
- R6: If `start_seen` is high while a frame is held, both slots are full and no pop is in progress, the held frame is dropped. The next entry written to the queue then carries `rd_dor` = 1. Entries written at any other time carry `rd_dor` = 0.
- R7: `data_avail` is 1 exactly when the queue holds at least one entry.
- R8: A pop of an empty queue changes nothing: the outputs keep showing the last entry that was removed.
- R9: While `rx_enable` is 0 the queue and the held frame are cleared, and completed frames are ignored.
- R10: A pop and a start bit in the same cycle while a frame is held lose no data and set no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; low flushes the queue |
| frame_done | input | 1 | One-cycle strobe: a frame has been assembled |
| frame_data | input | DATA_W | Byte of the completed frame |
| frame_bit9 | input | 1 | Ninth data bit of the completed frame |
| frame_ferr | input | 1 | Frame error of the completed frame |
| start_seen | input | 1 | One-cycle pulse: a new start bit was detected |
| data_pop | input | 1 | Data read; removes the head entry |
| rd_data | output | DATA_W | Byte of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rd_ferr | output | 1 | Frame error of the head entry |
| rd_dor | output | 1 | Overrun flag of the head entry |
| data_avail | output | 1 | Queue is not empty |

## Verification
A pop and a start bit can land in the same cycle while a frame is parked in the shifter and both slots are full. The pop frees a slot in that same cycle, so the start bit must not count as an overrun. The bench provokes this by filling both slots, completing a third frame, and then raising `start_seen` and `data_pop` together. It judges the outcome by popping out the parked frame in order with its overrun flag still clear. The same vectors also raise the start bit without a pop, which must drop the parked frame and flag the next entry.

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_bit9,
  input  logic              frame_ferr,
  input  logic              start_seen,
  input  logic              data_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              rd_dor,
  output logic              data_avail
);
  localparam int HOLD_W = DATA_W + 2;
  localparam int ENT_W  = HOLD_W + 1;

  logic [ENT_W-1:0]  slot [2];
  logic              rd_ptr, wr_ptr;
  logic [1:0]        count;
  logic              hold_valid;
  logic [HOLD_W-1:0] hold_ent;
  logic              dor_pend;

  logic              pop_ok, space, wr_req, to_hold, lost;
  logic [HOLD_W-1:0] new_ent;
  logic [ENT_W-1:0]  wr_ent, head;

  assign new_ent = {frame_data, frame_bit9, frame_ferr};
  assign pop_ok  = rx_enable && data_pop && (count != 2'd0);
  assign space   = (count != 2'd2) || pop_ok;
  assign wr_req  = rx_enable && (hold_valid || frame_done) && space;
  assign wr_ent  = {hold_valid ? hold_ent : new_ent, dor_pend};
  assign to_hold = rx_enable && frame_done && !hold_valid && !space;
  assign lost    = rx_enable && start_seen && hold_valid && !space;

  assign head       = slot[(count == 2'd0) ? ~rd_ptr : rd_ptr];
  assign {rd_data, rd_bit9, rd_ferr, rd_dor} = head;
  assign data_avail = (count != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) slot[i] <= '0;
      rd_ptr     <= 1'b0;
      wr_ptr     <= 1'b0;
      count      <= 2'd0;
      hold_valid <= 1'b0;
      hold_ent   <= '0;
      dor_pend   <= 1'b0;
    end else if (!rx_enable) begin
      rd_ptr     <= 1'b0;
      wr_ptr     <= 1'b0;
      count      <= 2'd0;
      hold_valid <= 1'b0;
      dor_pend   <= 1'b0;
    end else begin
      if (wr_req) begin
        slot[wr_ptr] <= wr_ent;
        wr_ptr       <= ~wr_ptr;
      end
      if (pop_ok) rd_ptr <= ~rd_ptr;
      count <= count + {1'b0, wr_req} - {1'b0, pop_ok};

      if (to_hold) begin
        hold_valid <= 1'b1;
        hold_ent   <= new_ent;
      end else if ((hold_valid && wr_req) || lost) begin
        hold_valid <= 1'b0;
      end

      if (lost)        dor_pend <= 1'b1;
      else if (wr_req) dor_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              frame_done,
  input logic              start_seen,
  input logic              data_pop,
  input logic              data_avail,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        count,
  input logic              hold_valid,
  input logic              dor_pend
);
  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && frame_done && !data_avail && !hold_valid |=> data_avail);

  p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && frame_done && count == 2'd2 && !data_pop |=> hold_valid);

  p_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && hold_valid && data_pop && count == 2'd2 |=> !hold_valid && count == 2'd2);

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && start_seen && hold_valid && count == 2'd2 && !data_pop |=> dor_pend && !hold_valid);

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && data_pop && !data_avail && !frame_done && !hold_valid |=> $stable(rd_data) && !data_avail);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !data_avail && !hold_valid);
endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .frame_done(frame_done),
  .start_seen(start_seen), .data_pop(data_pop), .data_avail(data_avail),
  .rd_data(rd_data), .count(count), .hold_valid(hold_valid), .dor_pend(dor_pend)
);

// File: tb/serial_rx_queue_bench.sv
module serial_rx_queue_bench;
  localparam int DW = 8;
  localparam int NV = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_enable = 1'b0, frame_done = 1'b0, frame_bit9 = 1'b0, frame_ferr = 1'b0;
  logic          start_seen = 1'b0, data_pop = 1'b0;
  logic [DW-1:0] frame_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_bit9, rd_ferr, rd_dor, data_avail;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_rx_queue #(.DATA_W(DW)) u_serial_rx_queue (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .frame_done(frame_done),
    .frame_data(frame_data), .frame_bit9(frame_bit9), .frame_ferr(frame_ferr),
    .start_seen(start_seen), .data_pop(data_pop), .rd_data(rd_data),
    .rd_bit9(rd_bit9), .rd_ferr(rd_ferr), .rd_dor(rd_dor), .data_avail(data_avail)
  );

  // {en,done,start,pop,bit9,ferr}, data, {chk,avail,bit9,ferr,dor}, expected data
  localparam logic [26:0] VEC [NV] = '{
    {6'b110010, 8'hA1, 5'b11100, 8'hA1},
    {6'b110001, 8'hB2, 5'b11100, 8'hA1},
    {6'b110000, 8'hC3, 5'b11100, 8'hA1},
    {6'b100100, 8'h00, 5'b11010, 8'hB2},
    {6'b100000, 8'h00, 5'b11010, 8'hB2},
    {6'b110000, 8'hD4, 5'b11010, 8'hB2},
    {6'b101000, 8'h00, 5'b11010, 8'hB2},
    {6'b100100, 8'h00, 5'b11000, 8'hC3},
    {6'b110010, 8'hE5, 5'b11000, 8'hC3},
    {6'b100100, 8'h00, 5'b11101, 8'hE5},
    {6'b100100, 8'h00, 5'b10101, 8'hE5},
    {6'b100100, 8'h00, 5'b10101, 8'hE5},
    {6'b110000, 8'h5A, 5'b11000, 8'h5A},
    {6'b110011, 8'h6B, 5'b11000, 8'h5A},
    {6'b110000, 8'h7C, 5'b11000, 8'h5A},
    {6'b101100, 8'h00, 5'b11110, 8'h6B},
    {6'b100100, 8'h00, 5'b11000, 8'h7C},
    {6'b000000, 8'h00, 5'b00000, 8'h00},
    {6'b010000, 8'h99, 5'b00000, 8'h00},
    {6'b110001, 8'h11, 5'b11010, 8'h11},
    {6'b100100, 8'h00, 5'b10010, 8'h11}
  };

  function automatic string tag(int i);
    case (i)
      0, 1, 13:   return "R3";
      2, 5, 14:   return "R4";
      3:          return "R5";
      4, 7:       return "R2";
      6, 8, 9:    return "R6";
      10, 12:     return "R7";
      11, 20:     return "R8";
      15, 16:     return "R10";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got avail/b9/fe/dor/data=%h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {data_avail, rd_bit9, rd_ferr, rd_dor, rd_data};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", outs(), 12'h000);
    rst_n = 1'b1;
    rx_enable = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {rx_enable, frame_done, start_seen, data_pop, frame_bit9, frame_ferr} = VEC[i][26:21];
      frame_data = VEC[i][20:13];
      @(negedge clk);
      if (VEC[i][12])
        check(tag(i), outs(), {VEC[i][11:8], VEC[i][7:0]});
      else
        check(tag(i), {data_avail, 11'h0}, {VEC[i][11], 11'h0});
    end

    // mid-run reset with two entries queued: R1
    {frame_done, start_seen, data_pop} = 3'b100;
    frame_data = 8'h3C; frame_bit9 = 1'b1; frame_ferr = 1'b1;
    @(negedge clk);
    frame_data = 8'h4D;
    @(negedge clk);
    frame_done = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", outs(), 12'h000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", outs(), 12'h000);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule